// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous memory whose reads and writes share one pipeline shape. A command (address, direction, lane enables, selects and a load/advance strobe) is captured on a rising clock edge. The data beat for that command happens in the next cycle, whether it is a read or a write. Read data comes straight from the array during that beat. Write data is captured at the edge that ends the beat. Reads and writes therefore interleave on consecutive cycles with no idle cycle on the data bus.

A load cycle starts a four-beat burst from an external address. Advance cycles step a 2-bit counter through the low address bits, in linear or interleaved order, and wrap after four beats. A low clock enable gates every edge. When clock enable is inactive, or the snooze input is high, the edge is ignored and the whole pipeline freezes. The data bus is split into a write-data input, a read-data output and an output-drive flag. The flag models the pad enable, which depends on the output-enable input, the snooze input and the current beat.

Top module: `zbt_sram_core`

## Requirements
- R1: A read load captured at edge N drives `rdata_o` with the word at that address and raises `drive_o` during the cycle after edge N. A write may be loaded at the very next edge, and reads and writes alternate with no idle cycle.
- R2: A write loaded at edge N takes its lane enables from edge N and its data from `wdata_i` at edge N+1. Lane 0 is `wdata_i[8:0]`, gated by `bw_ni[0]`, and lane 1 is `wdata_i[17:9]`, gated by `bw_ni[1]`. Each enable is active low, and any combination of lanes may be written.
- R3: A load with `cs1_ni` high, `cs2_ni` high or `cs3_i` low is a deselect. A beat already in flight still completes, and `drive_o` is low in the cycle after the deselect.
- R4: The direction (`we_ni` low for write, high for read) is taken only on a load. On advance cycles `we_ni` is ignored and the burst keeps its loaded direction.
- R5: With base low bits s and beat k (0 to 3), the beat address low bits are (s+k) mod 4 when `lin_mode_i` is 1 and s XOR k when it is 0. The upper bits come from the base, and the sequence wraps to k=0 after the fourth beat.
- R6: An advance cycle after a deselect or after reset starts no access, and `drive_o` stays low.
- R7: A write beat with both lane enables high stores nothing, but it still steps the burst counter.
- R8: When `cke_ni` is high at an edge, the edge is ignored. The pipeline and burst state hold, `rdata_o` and `drive_o` keep their values, and a pending write commits at the next enabled edge using the data present there.
- R9: `drive_o` is low whenever `oe_ni` is high, with no clock involved. It is also low during every write beat, whatever `oe_ni` is.
- R10: While `snooze_i` is high, edges are ignored as with `cke_ni` high, and `drive_o` is low.
- R11: Asserting `rst_ni` low puts the pipeline in the deselected state with `drive_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_ni | input | 1 | Chip select, active low |
| cs3_i | input | 1 | Chip select, active high |
| ld_ni | input | 1 | Low: load new command; high: advance burst |
| we_ni | input | 1 | Direction on load: low write, high read |
| bw_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved (static level) |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| snooze_i | input | 1 | Snooze: freezes the pipeline and disables drive |
| wdata_i | input | LANES*LANE_W | Write data for the current write beat |
| rdata_o | output | LANES*LANE_W | Read data for the current read beat, zero when not driven |
| drive_o | output | 1 | Output drivers enabled |

## Verification
The array is first filled through linear write bursts. Directed patterns then set apart the two burst orders and their wrap, single-lane and aborted writes, a direction flip during advance, each of the three select pins on its own, and stalls placed on both read and write beats. A stall on a write beat shows whether data is taken at the enabled edge rather than the stalled one. Alternating single-beat reads and writes to one address show whether the late write reaches the array before the read beat that follows it. A long run of seeded random commands then mixes stalls, snooze, output-enable toggles and deselects, with every cycle compared against a bench model of the pipeline.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    BEAT_IDLE  = 2'd0,
    BEAT_READ  = 2'd1,
    BEAT_WRITE = 2'd2
  } beat_e;
endpackage

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [BURST_W-1:0] step_i,
  input  logic               lin_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [BURST_W-1:0] low;

  always_comb begin
    if (lin_i) low = base_i[BURST_W-1:0] + step_i;
    else       low = base_i[BURST_W-1:0] ^ step_i;
  end

  assign addr_o = {base_i[ADDR_W-1:BURST_W], low};
endmodule

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_ni,
  input  logic              sel_i,
  input  logic              we_ni,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_ni,
  output beat_e             beat_op_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [LANES-1:0]  beat_bw_no
);
  logic               act_q;
  beat_e              dir_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;
  logic [BURST_W-1:0] step_nxt;
  logic [ADDR_W-1:0]  seq_base;
  logic [BURST_W-1:0] seq_step;
  logic [ADDR_W-1:0]  seq_addr;
  beat_e              load_dir;

  always_comb begin
    step_nxt = step_q + 1'b1;
    seq_base = ld_ni ? base_q : addr_i;
    seq_step = ld_ni ? step_nxt : '0;
    load_dir = we_ni ? BEAT_READ : BEAT_WRITE;
  end

  zbt_burst_addr #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_seq (
    .base_i(seq_base),
    .step_i(seq_step),
    .lin_i (lin_i),
    .addr_o(seq_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      dir_q       <= BEAT_READ;
      base_q      <= '0;
      step_q      <= '0;
      beat_op_o   <= BEAT_IDLE;
      beat_addr_o <= '0;
      beat_bw_no  <= '1;
    end else if (en_i) begin
      if (!ld_ni) begin
        if (sel_i) begin
          act_q       <= 1'b1;
          dir_q       <= load_dir;
          base_q      <= addr_i;
          step_q      <= '0;
          beat_op_o   <= load_dir;
          beat_addr_o <= seq_addr;
          beat_bw_no  <= bw_ni;
        end else begin
          act_q     <= 1'b0;
          beat_op_o <= BEAT_IDLE;
        end
      end else if (act_q) begin
        step_q      <= step_nxt;
        beat_op_o   <= dir_q;
        beat_addr_o <= seq_addr;
        beat_bw_no  <= bw_ni;
      end else begin
        beat_op_o <= BEAT_IDLE;
      end
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(beat_op_o) && $stable(beat_addr_o) && $stable(step_q) && $stable(act_q));

  assert_deselect_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_ni && !sel_i) |=> beat_op_o == BEAT_IDLE);

  assert_idle_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_ni && !act_q) |=> beat_op_o == BEAT_IDLE);

  assert_dir_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_ni && act_q) |=> beat_op_o == $past(beat_op_o));

  assert_step_incr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ld_ni && act_q) |=> (step_q - $past(step_q)) == BURST_W'(1));

  assert_load_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_ni && sel_i) |=> step_q == '0 && beat_addr_o == $past(addr_i));
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [LANES-1:0]        wr_lane_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_lane_i[l]) bank[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = bank[addr_i];
  end
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              cs1_ni,
  input  logic              cs2_ni,
  input  logic              cs3_i,
  input  logic              ld_ni,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lin_mode_i,
  input  logic              oe_ni,
  input  logic              snooze_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              edge_en;
  logic              selected;
  beat_e             beat_op;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_bw_n;
  logic [DATA_W-1:0] array_rd;
  logic              commit;

  assign edge_en  = !cke_ni && !snooze_i;
  assign selected = !cs1_ni && !cs2_ni && cs3_i;

  zbt_cmd_ctrl #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W),
    .LANES  (LANES)
  ) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (edge_en),
    .ld_ni      (ld_ni),
    .sel_i      (selected),
    .we_ni      (we_ni),
    .lin_i      (lin_mode_i),
    .addr_i     (addr_i),
    .bw_ni      (bw_ni),
    .beat_op_o  (beat_op),
    .beat_addr_o(beat_addr),
    .beat_bw_no (beat_bw_n)
  );

  // late write: data for the beat is taken at the edge that closes it
  assign commit = edge_en && (beat_op == BEAT_WRITE);

  zbt_mem_array #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (commit),
    .wr_lane_i(~beat_bw_n),
    .addr_i   (beat_addr),
    .wdata_i  (wdata_i),
    .rdata_o  (array_rd)
  );

  assign drive_o = (beat_op == BEAT_READ) && !oe_ni && !snooze_i;
  assign rdata_o = drive_o ? array_rd : '0;

  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni || snooze_i) |-> !drive_o);

  assert_write_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_op == BEAT_WRITE) |-> !drive_o);

  assert_desel_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_en && !ld_ni && !selected) |=> !drive_o);
endmodule

// File: tb/sim_zbt_sram_core.sv
module sim_zbt_sram_core;
  localparam int AW = 6, LW = 9, NL = 2, DW = NL * LW, DEPTH = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0, cke_ni = 1'b0;
  logic cs1_ni = 1'b1, cs2_ni = 1'b0, cs3_i = 1'b1;
  logic ld_ni = 1'b0, we_ni = 1'b1, oe_ni = 1'b0, snooze_i = 1'b0, lin_mode_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [NL-1:0] bw_ni = '1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic drive_o;

  zbt_sram_core u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_ni(cke_ni), .cs1_ni(cs1_ni), .cs2_ni(cs2_ni),
    .cs3_i(cs3_i), .ld_ni(ld_ni), .we_ni(we_ni), .bw_ni(bw_ni), .addr_i(addr_i),
    .lin_mode_i(lin_mode_i), .oe_ni(oe_ni), .snooze_i(snooze_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .drive_o(drive_o)
  );

  always #2 clk_i = ~clk_i;

  // bench model: 0 idle, 1 read, 2 write
  logic [DW-1:0] m_mem [DEPTH];
  logic m_act = 1'b0, m_wr = 1'b0;
  logic [AW-1:0] m_base = '0, m_paddr = '0;
  logic [1:0] m_k = '0, m_op = '0;
  logic [NL-1:0] m_pbw = '1;
  int n_total = 0, n_fail = 0;
  string cur_tag = "R11";
  bit done = 1'b0;

  function automatic logic [AW-1:0] burst_at(logic [AW-1:0] b, logic [1:0] k, logic lin);
    logic [1:0] lo;
    lo = lin ? b[1:0] + k : b[1:0] ^ k;
    return {b[AW-1:2], lo};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!cke_ni && !snooze_i) begin
      if (m_op == 2'd2)
        for (int l = 0; l < NL; l++)
          if (!m_pbw[l]) m_mem[m_paddr][l*LW +: LW] = wdata_i[l*LW +: LW];
      if (!ld_ni) begin
        if (!cs1_ni && !cs2_ni && cs3_i) begin
          m_act = 1'b1; m_wr = !we_ni; m_base = addr_i; m_k = '0;
          m_op = we_ni ? 2'd1 : 2'd2; m_paddr = addr_i; m_pbw = bw_ni;
        end else begin
          m_act = 1'b0; m_op = '0;
        end
      end else if (m_act) begin
        m_k = m_k + 2'd1;
        m_paddr = burst_at(m_base, m_k, lin_mode_i);
        m_op = m_wr ? 2'd2 : 2'd1;
        m_pbw = bw_ni;
      end else begin
        m_op = '0;
      end
    end
  endtask

  task automatic check_out();
    logic exp_drv;
    exp_drv = (m_op == 2'd1) && !oe_ni && !snooze_i;
    chk(drive_o === exp_drv, "drive_o", 32'(drive_o), 32'(exp_drv));
    if (exp_drv) chk(rdata_o === m_mem[m_paddr], "rdata_o", 32'(rdata_o), 32'(m_mem[m_paddr]));
  endtask

  task automatic tick();
    wdata_i = DW'($urandom);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_out();
  endtask

  task automatic go(input logic ld, input logic we, input logic [AW-1:0] a, input logic [NL-1:0] bw);
    cs1_ni = 1'b0; cs2_ni = 1'b0; cs3_i = 1'b1;
    ld_ni = ld; we_ni = we; addr_i = a; bw_ni = bw;
    tick();
  endtask

  task automatic desel(input int kind);
    ld_ni = 1'b0;
    cs1_ni = (kind == 0); cs2_ni = (kind == 1); cs3_i = (kind != 2);
    tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL R1 watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3E));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cur_tag = "R11";
    chk(drive_o === 1'b0, "drive_o after reset", 32'(drive_o), 32'd0);

    cur_tag = "R6";  // advance straight after reset
    go(1'b1, 1'b1, 6'd3, 2'b00);
    go(1'b1, 1'b1, 6'd3, 2'b00);

    cur_tag = "R2";  // fill through linear write bursts
    lin_mode_i = 1'b1;
    for (int b = 0; b < DEPTH / 4; b++) begin
      go(1'b0, 1'b0, AW'(b * 4), 2'b00);
      for (int k = 0; k < 3; k++) go(1'b1, 1'b1, '0, 2'b00);
    end
    desel(0);

    cur_tag = "R5";  // linear from 6, wraps
    lin_mode_i = 1'b1;
    go(1'b0, 1'b1, 6'd6, 2'b11);
    for (int k = 0; k < 6; k++) go(1'b1, 1'b0, '0, 2'b11);
    lin_mode_i = 1'b0;  // interleaved from 5: 5,4,7,6
    go(1'b0, 1'b1, 6'd5, 2'b11);
    for (int k = 0; k < 5; k++) go(1'b1, 1'b1, '0, 2'b11);
    desel(1);
    lin_mode_i = 1'b1;

    cur_tag = "R2";
    go(1'b0, 1'b0, 6'd9, 2'b10);
    go(1'b0, 1'b0, 6'd10, 2'b01);
    go(1'b0, 1'b1, 6'd9, 2'b11);
    go(1'b0, 1'b1, 6'd10, 2'b11);
    desel(2);

    cur_tag = "R7";
    go(1'b0, 1'b0, 6'd12, 2'b11);
    go(1'b1, 1'b0, '0, 2'b11);
    go(1'b1, 1'b0, '0, 2'b00);
    go(1'b0, 1'b1, 6'd12, 2'b11);
    go(1'b1, 1'b1, '0, 2'b11);
    go(1'b1, 1'b1, '0, 2'b11);
    desel(0);

    cur_tag = "R4";
    go(1'b0, 1'b0, 6'd20, 2'b00);
    go(1'b1, 1'b1, '0, 2'b00);
    go(1'b0, 1'b1, 6'd20, 2'b00);
    go(1'b1, 1'b0, '0, 2'b00);
    go(1'b1, 1'b0, '0, 2'b00);
    desel(1);

    cur_tag = "R1";  // alternate write/read on one word
    for (int k = 0; k < 4; k++) begin
      go(1'b0, 1'b0, 6'd33, 2'b00);
      go(1'b0, 1'b1, 6'd33, 2'b11);
    end
    desel(0);

    cur_tag = "R3";
    for (int kind = 0; kind < 3; kind++) begin
      go(1'b0, 1'b1, AW'(30 + kind), 2'b11);
      desel(kind);
      cur_tag = "R6";
      go(1'b1, 1'b1, '0, 2'b11);
      cur_tag = "R3";
    end

    cur_tag = "R8";
    go(1'b0, 1'b1, 6'd40, 2'b11);
    cke_ni = 1'b1;
    go(1'b0, 1'b0, 6'd50, 2'b00);
    go(1'b1, 1'b0, 6'd51, 2'b00);
    cke_ni = 1'b0;
    go(1'b1, 1'b1, '0, 2'b11);
    go(1'b0, 1'b0, 6'd41, 2'b00);
    cke_ni = 1'b1;
    go(1'b0, 1'b1, 6'd41, 2'b11);
    go(1'b0, 1'b1, 6'd41, 2'b11);
    cke_ni = 1'b0;
    go(1'b0, 1'b1, 6'd41, 2'b11);
    desel(2);

    cur_tag = "R9";
    go(1'b0, 1'b1, 6'd44, 2'b11);
    oe_ni = 1'b1;
    #1;
    chk(drive_o === 1'b0, "drive_o async oe", 32'(drive_o), 32'd0);
    go(1'b1, 1'b1, '0, 2'b11);
    oe_ni = 1'b0;
    #1;
    chk(drive_o === 1'b1, "drive_o async oe", 32'(drive_o), 32'd1);
    go(1'b0, 1'b0, 6'd45, 2'b00);
    desel(0);

    cur_tag = "R10";
    go(1'b0, 1'b1, 6'd48, 2'b11);
    snooze_i = 1'b1;
    go(1'b0, 1'b0, 6'd2, 2'b00);
    go(1'b1, 1'b0, 6'd2, 2'b00);
    snooze_i = 1'b0;
    go(1'b1, 1'b1, '0, 2'b11);
    go(1'b1, 1'b1, '0, 2'b11);
    desel(1);

    cur_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      int d;
      cke_ni = ($urandom % 100) < 8;
      snooze_i = ($urandom % 100) < 3;
      oe_ni = ($urandom % 100) < 10;
      if (i % 200 == 0) lin_mode_i = 1'($urandom);
      d = $urandom % 12;
      cs1_ni = (d == 0); cs2_ni = (d == 1); cs3_i = (d != 2);
      ld_ni = 1'($urandom);
      we_ni = 1'($urandom);
      addr_i = AW'($urandom);
      bw_ni = NL'($urandom);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule